// File: doc/BRIEF.md
# HDLC Bit-Stream Receiver with Tagged Receive FIFO

This block turns a serial bit stream, qualified by a per-bit valid strobe, into bytes of HDLC frames. It finds flag sequences, deletes the zeros the transmitter stuffed after runs of five ones, assembles bytes least significant bit first and runs a reflected CRC-16 over each frame. Every received byte, including the two FCS bytes, is pushed into a 32-entry receive FIFO as a data entry. When a frame ends, one more entry marks the end and tells how it ended: a good closing flag, a bad one, or an abort.

A host drains the FIFO through a one-cycle registered read port and watches six clear-on-read status latches. The latches report a go-ahead sequence, an end entry written, an end entry reaching the FIFO head (or a read of an empty FIFO), an abort late in a frame, the fill level crossing its threshold, and an overflow. After an overflow the receiver stops writing until it sees the next flag.

Top module: `hdlc_rx_status`

## Requirements
- R1: Frames open and close on the flag 01111110. A 0 that follows five 1s inside a frame is deleted. Each completed byte (first bit received is bit 0) is written as an entry with tag 0 (data), FCS bytes included. A flag right after a flag writes nothing.
- R2: A closing flag that lands on a byte boundary, with CRC residue 0xF0B8 (poly 0x8408 reflected, preset 0xFFFF), writes an end entry with tag 1 and data 0x00.
- R3: A closing flag after a bad FCS, or after a bit count that is not a multiple of 8, writes an end entry with tag 2 and data 0x00.
- R4: Seven 1s in a row inside a frame end it. If at least 26 de-stuffed bits came before the abort sequence (its leading 0 and first six 1s not counted), the end entry has tag 3 and status bit 2 sets. If fewer came, the end entry has tag 2 and bit 2 stays clear.
- R5: Status bit 5 sets whenever a 0 followed by seven 1s is received, inside or outside a frame.
- R6: Status bit 4 sets when an end entry (tag 1, 2 or 3) is written into the FIFO.
- R7: Status bit 3 sets when an end entry becomes the FIFO head, and when the host reads while the FIFO is empty.
- R8: Status bit 1 sets when the FIFO level goes from 16 or less to more than 16.
- R9: A write attempted while the FIFO holds 32 entries sets status bit 0 and stops all writes, the end entry included, until the next flag. If the FIFO is still full, the next write overflows again.
- R10: A read strobe returns the head entry's byte and tag on rd_data/rd_tag after the next clock edge. Level counts the stored entries.
- R11: Asserting st_rd clears every status bit at the next edge, except a bit whose set event happens in that same cycle. That bit stays set.
- R12: After reset, the status, the level and the read outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Received line bit |
| bit_vld | input | 1 | bit_in is valid this cycle |
| rd_en | input | 1 | Host FIFO read strobe |
| rd_data | output | 8 | Byte of the last read entry |
| rd_tag | output | 2 | Tag of the last read entry: 0 data, 1 good end, 2 bad end, 3 abort end |
| level | output | 6 | Number of stored FIFO entries |
| st_rd | input | 1 | Status read strobe; clears the latches |
| status | output | 6 | Latches: 0 overflow, 1 above threshold, 2 frame abort, 3 end at head, 4 end written, 5 go-ahead |

## Verification
A bit sampled at clock edge E produces its FIFO entry, the level change and the status bits 0, 1, 2, 4 and 5 at edge E+1. The end-at-head bit appears one edge after the FIFO read or write that exposes the end entry. The empty-read case sets it at the read edge itself. Read data is valid after the edge that samples rd_en. The bench drives every input on falling edges and leaves several idle cycles after each frame before it samples status. It reads one entry per strobe and compares it at the following falling edge, so each sample comes after every result is due.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  typedef enum logic [1:0] {
    TAG_DATA  = 2'd0,
    TAG_GOOD  = 2'd1,
    TAG_BAD   = 2'd2,
    TAG_ABORT = 2'd3
  } tag_e;

  localparam logic [15:0] CRC_PRESET  = 16'hFFFF;
  localparam logic [15:0] CRC_RESIDUE = 16'hF0B8;
  localparam logic [15:0] CRC_POLY    = 16'h8408;

  localparam int ST_OVF   = 0;
  localparam int ST_THR   = 1;
  localparam int ST_ABORT = 2;
  localparam int ST_HEAD  = 3;
  localparam int ST_EOPW  = 4;
  localparam int ST_GA    = 5;
  localparam int ST_W     = 6;

  function automatic logic [15:0] crc_step(logic [15:0] c, logic b);
    return (c[0] ^ b) ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
  endfunction
endpackage

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
#(
  parameter int ABORT_MIN_BITS = 26,
  localparam int NW = $clog2(ABORT_MIN_BITS + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_in,
  input  logic       bit_vld,
  output logic       ent_vld,
  output logic [7:0] ent_data,
  output tag_e       ent_tag,
  output logic       flag_evt,
  output logic       seven_evt,
  output logic       abort_evt
);
  logic [2:0]    ones;
  logic          in_frame;
  logic [6:0]    dly;
  logic [2:0]    dcnt;
  logic [7:0]    acc;
  logic [2:0]    bpos;
  logic [NW-1:0] nbits;
  logic [15:0]   crc;

  logic is_flag, is_seven, is_stuff, take, commit, cbit, late;
  logic [7:0]  acc_nxt;
  logic [15:0] crc_nxt;

  always_comb begin
    is_flag  = bit_vld && !bit_in && (ones == 3'd6);
    is_seven = bit_vld && bit_in && (ones == 3'd6);
    is_stuff = bit_vld && !bit_in && (ones == 3'd5) && in_frame;
    take     = bit_vld && in_frame && !is_flag && !is_seven && !is_stuff;
    commit   = take && (dcnt == 3'd7);
    cbit     = dly[6];
    acc_nxt  = {cbit, acc[7:1]};
    crc_nxt  = crc_step(crc, cbit);
    late     = (nbits >= NW'(ABORT_MIN_BITS));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ones      <= '0;
      in_frame  <= 1'b0;
      dly       <= '0;
      dcnt      <= '0;
      acc       <= '0;
      bpos      <= '0;
      nbits     <= '0;
      crc       <= CRC_PRESET;
      ent_vld   <= 1'b0;
      ent_data  <= '0;
      ent_tag   <= TAG_DATA;
      flag_evt  <= 1'b0;
      seven_evt <= 1'b0;
      abort_evt <= 1'b0;
    end else begin
      ent_vld   <= 1'b0;
      flag_evt  <= 1'b0;
      seven_evt <= 1'b0;
      abort_evt <= 1'b0;
      if (bit_vld)
        ones <= bit_in ? ((ones == 3'd7) ? ones : ones + 3'd1) : 3'd0;
      if (is_flag) begin
        flag_evt <= 1'b1;
        if (in_frame && nbits != '0) begin
          ent_vld  <= 1'b1;
          ent_data <= 8'h00;
          ent_tag  <= (bpos == 3'd0 && crc == CRC_RESIDUE) ? TAG_GOOD : TAG_BAD;
        end
        in_frame <= 1'b1;
        dcnt     <= '0;
        bpos     <= '0;
        nbits    <= '0;
        crc      <= CRC_PRESET;
      end else if (is_seven) begin
        seven_evt <= 1'b1;
        if (in_frame && nbits != '0) begin
          ent_vld   <= 1'b1;
          ent_data  <= 8'h00;
          ent_tag   <= late ? TAG_ABORT : TAG_BAD;
          abort_evt <= late;
        end
        in_frame <= 1'b0;
      end else if (take) begin
        dly <= {dly[5:0], bit_in};
        if (dcnt != 3'd7) dcnt <= dcnt + 3'd1;
        if (commit) begin
          acc  <= acc_nxt;
          crc  <= crc_nxt;
          bpos <= bpos + 3'd1;
          if (!late) nbits <= nbits + NW'(1);
          if (bpos == 3'd7) begin
            ent_vld  <= 1'b1;
            ent_data <= acc_nxt;
            ent_tag  <= TAG_DATA;
          end
        end
      end
    end
  end
endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  parameter int TW    = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic [TW-1:0] wr_tag,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic [TW-1:0] rd_tag,
  output logic [TW-1:0] head_tag,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] dmem [DEPTH];
  logic [TW-1:0] tmem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          wr_ok, rd_ok;

  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign wr_ok    = wr_en && !full;
  assign rd_ok    = rd_en && !empty;
  assign head_tag = tmem[rptr];

  always_ff @(posedge clk) begin
    if (wr_ok) begin
      dmem[wptr] <= wr_data;
      tmem[wptr] <= wr_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr    <= '0;
      rptr    <= '0;
      count   <= '0;
      rd_data <= '0;
      rd_tag  <= '0;
    end else begin
      if (wr_ok) wptr <= wptr + AW'(1);
      if (rd_ok) begin
        rd_data <= dmem[rptr];
        rd_tag  <= tmem[rptr];
        rptr    <= rptr + AW'(1);
      end
      count <= count + CW'(wr_ok) - CW'(rd_ok);
    end
  end
endmodule

// File: rtl/hdlc_rx_status.sv
module hdlc_rx_status
  import hdlc_rx_pkg::*;
#(
  parameter int DEPTH          = 32,
  parameter int THRESH         = 16,
  parameter int ABORT_MIN_BITS = 26,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_in,
  input  logic          bit_vld,
  input  logic          rd_en,
  output logic [7:0]    rd_data,
  output logic [1:0]    rd_tag,
  output logic [CW-1:0] level,
  input  logic          st_rd,
  output logic [ST_W-1:0] status
);
  logic       ent_vld, flag_evt, seven_evt, abort_evt;
  logic [7:0] ent_data;
  tag_e       ent_tag;
  logic [1:0] head_tag;
  logic       fifo_full, fifo_empty;
  logic       rx_off, wr_req, wr_ok, rd_ok;
  logic       head_end, head_end_q, rd_ok_q;
  logic [CW-1:0]   cnt_nxt;
  logic [ST_W-1:0] set_ev;

  hdlc_rx_deframer #(.ABORT_MIN_BITS(ABORT_MIN_BITS)) u_deframer (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_vld(bit_vld),
    .ent_vld(ent_vld), .ent_data(ent_data), .ent_tag(ent_tag),
    .flag_evt(flag_evt), .seven_evt(seven_evt), .abort_evt(abort_evt)
  );

  hdlc_rx_fifo #(.DEPTH(DEPTH), .DW(8), .TW(2)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(wr_req), .wr_data(ent_data),
    .wr_tag(ent_tag), .rd_en(rd_en), .rd_data(rd_data), .rd_tag(rd_tag),
    .head_tag(head_tag), .count(level), .full(fifo_full), .empty(fifo_empty)
  );

  always_comb begin
    wr_req   = ent_vld && !rx_off;
    wr_ok    = wr_req && !fifo_full;
    rd_ok    = rd_en && !fifo_empty;
    cnt_nxt  = level + CW'(wr_ok) - CW'(rd_ok);
    head_end = !fifo_empty && (head_tag != TAG_DATA);
    set_ev           = '0;
    set_ev[ST_OVF]   = wr_req && fifo_full;
    set_ev[ST_THR]   = (level <= CW'(THRESH)) && (cnt_nxt > CW'(THRESH));
    set_ev[ST_ABORT] = abort_evt;
    set_ev[ST_HEAD]  = (head_end && (!head_end_q || rd_ok_q)) || (rd_en && fifo_empty);
    set_ev[ST_EOPW]  = wr_ok && (ent_tag != TAG_DATA);
    set_ev[ST_GA]    = seven_evt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_off     <= 1'b0;
      head_end_q <= 1'b0;
      rd_ok_q    <= 1'b0;
      status     <= '0;
    end else begin
      if (set_ev[ST_OVF])  rx_off <= 1'b1;
      else if (flag_evt)   rx_off <= 1'b0;
      head_end_q <= head_end;
      rd_ok_q    <= rd_ok;
      status     <= (st_rd ? '0 : status) | set_ev;
    end
  end
endmodule

// File: rtl/hdlc_rx_checker.sv
module hdlc_rx_checker #(
  parameter int DEPTH  = 32,
  parameter int THRESH = 16,
  parameter int CW     = 6,
  parameter int SW     = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          st_rd,
  input logic [SW-1:0] status,
  input logic [SW-1:0] set_ev,
  input logic [CW-1:0] level,
  input logic          wr_req,
  input logic          fifo_full,
  input logic          rx_off
);
  a_r11_clear: assert property (@(posedge clk) disable iff (rst)
    st_rd |=> ((status & ~$past(set_ev)) == '0));

  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !st_rd |=> ((status & $past(status)) == $past(status)));

  a_r9_overflow: assert property (@(posedge clk) disable iff (rst)
    (wr_req && fifo_full) |=> (status[0] && rx_off));

  a_r9_level_max: assert property (@(posedge clk) disable iff (rst)
    level <= CW'(DEPTH));

  a_r9_off_no_write: assert property (@(posedge clk) disable iff (rst)
    rx_off |=> (level <= $past(level)));

  a_r8_threshold: assert property (@(posedge clk) disable iff (rst)
    (level > CW'(THRESH) && $past(level) <= CW'(THRESH)) |-> status[1]);
endmodule

bind hdlc_rx_status hdlc_rx_checker #(
  .DEPTH(DEPTH), .THRESH(THRESH), .CW(CW), .SW(hdlc_rx_pkg::ST_W)
) u_chk (
  .clk(clk), .rst(rst), .st_rd(st_rd), .status(status), .set_ev(set_ev),
  .level(level), .wr_req(wr_req), .fifo_full(fifo_full), .rx_off(rx_off)
);

// File: tb/hdlc_rx_status_bench.sv
module hdlc_rx_status_bench;
  logic       clk = 1'b0;
  logic       rst, bit_in, bit_vld, rd_en, st_rd;
  logic [7:0] rd_data;
  logic [1:0] rd_tag;
  logic [5:0] level;
  logic [5:0] status;

  always #5 clk = ~clk;

  hdlc_rx_status u_hdlc_rx_status (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_vld(bit_vld), .rd_en(rd_en),
    .rd_data(rd_data), .rd_tag(rd_tag), .level(level), .st_rd(st_rd),
    .status(status)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [9:0] exp_q[$];
  bit model_off = 0;
  int ones_tx = 0;
  logic [7:0] fb [0:63];
  int flen;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int k = 0; k < 8; k++)
      r = (r[0] ^ d[k]) ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    return r;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); bit_in = b; bit_vld = 1'b1;
    @(negedge clk); bit_vld = 1'b0;
  endtask

  task automatic send_data_bit(input logic b);
    send_bit(b);
    if (b) begin
      ones_tx++;
      if (ones_tx == 5) begin send_bit(1'b0); ones_tx = 0; end
    end else ones_tx = 0;
  endtask

  task automatic send_flag();
    send_bit(0);
    for (int k = 0; k < 6; k++) send_bit(1);
    send_bit(0);
    ones_tx = 0;
  endtask

  // R9 model: entries beyond 32 are dropped until the next flag
  task automatic push_exp(input logic [9:0] v);
    if (model_off) return;
    if (exp_q.size() == 32) model_off = 1;
    else exp_q.push_back(v);
  endtask

  task automatic send_frame(input int extra, input bit corrupt);
    logic [15:0] c = 16'hFFFF;
    logic [15:0] fcs;
    for (int i = 0; i < flen; i++) c = crc_byte(c, fb[i]);
    fcs = ~c;
    fb[flen] = fcs[7:0];
    fb[flen+1] = fcs[15:8];
    if (corrupt) fb[0] = fb[0] ^ 8'h10;
    send_flag();
    for (int i = 0; i < flen + 2; i++) begin
      for (int k = 0; k < 8; k++) send_data_bit(fb[i][k]);
      push_exp({2'd0, fb[i]});
    end
    for (int k = 0; k < extra; k++) send_data_bit(1'b0);
    send_flag();
    push_exp({((extra != 0 || corrupt) ? 2'd2 : 2'd1), 8'h00});
    model_off = 0;
    idle(4);
  endtask

  task automatic send_abort(input int nbits);
    send_flag();
    for (int k = 0; k < nbits; k++) send_data_bit(1'b0);
    send_bit(0);
    for (int k = 0; k < 7; k++) send_bit(1);
    for (int k = 0; k < nbits / 8; k++) push_exp(10'h000);
    push_exp({((nbits >= 26) ? 2'd3 : 2'd2), 8'h00});
    idle(4);
  endtask

  task automatic status_check(input string req, input int exp);
    check(req, status, exp);
    @(negedge clk); st_rd = 1'b1;
    @(negedge clk); st_rd = 1'b0;
  endtask

  task automatic read_all();
    logic [9:0] e;
    string req;
    while (level != 0) begin
      @(negedge clk); rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0;
      e = (exp_q.size() != 0) ? exp_q.pop_front() : 10'h3FF;
      case (e[9:8])
        2'd0: req = "R1_R10 data";
        2'd1: req = "R2 good end";
        2'd2: req = "R3 bad end";
        default: req = "R4 abort end";
      endcase
      check(req, {rd_tag, rd_data}, e);
    end
    check("R10 entries left", exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1; bit_in = 0; bit_vld = 0; rd_en = 0; st_rd = 0;
    idle(5);
    rst = 0;
    idle(2);
    check("R12 status", status, 0);
    check("R12 level", level, 0);
    check("R12 read outputs", {rd_tag, rd_data}, 0);

    // directed: frame with long runs of ones (stuffing), good FCS
    flen = 4; fb[0] = 8'hFF; fb[1] = 8'h7E; fb[2] = 8'h3F; fb[3] = 8'hF8;
    send_frame(0, 0);
    status_check("R6 end written", 6'h10);
    read_all();
    status_check("R7 end at head", 6'h08);

    // random frames: good, bad FCS, non-aligned
    for (int n = 0; n < 20; n++) begin
      int sel;
      flen = 1 + ($urandom % 8);
      for (int i = 0; i < flen; i++) fb[i] = 8'($urandom);
      sel = $urandom % 5;
      send_frame((sel == 0) ? 1 + ($urandom % 7) : 0, sel == 1);
      status_check("R6 end written", 6'h10);
      read_all();
      status_check("R7 end at head", 6'h08);
    end

    // aborts on both sides of the 26-bit boundary
    send_abort(26);
    status_check("R4 late abort", 6'h34);
    read_all();
    status_check("R7 after abort", 6'h08);
    send_abort(25);
    status_check("R4 early abort ignored", 6'h30);
    read_all();
    status_check("R7 after short abort", 6'h08);

    // go-ahead between frames
    send_flag();
    send_bit(0);
    for (int k = 0; k < 7; k++) send_bit(1);
    idle(4);
    status_check("R5 go-ahead", 6'h20);
    check("R5 no entry", level, 0);

    // empty read in the same cycle as a status read
    @(negedge clk); rd_en = 1; st_rd = 1;
    @(negedge clk); rd_en = 0; st_rd = 0;
    status_check("R11 set wins over clear", 6'h08);
    check("R11 cleared", status, 0);

    // overflow, repeated overflow, recovery
    flen = 34;
    for (int i = 0; i < flen; i++) fb[i] = 8'($urandom);
    send_frame(0, 0);
    check("R9 level full", level, 32);
    status_check("R8_R9 overflow and threshold", 6'h03);
    flen = 2; fb[0] = 8'h5A; fb[1] = 8'hC3;
    send_frame(0, 0);
    status_check("R9 overflow again", 6'h01);
    read_all();
    status_check("R9 no end entry kept", 6'h00);
    flen = 3; fb[0] = 8'h11; fb[1] = 8'h22; fb[2] = 8'h33;
    send_frame(0, 0);
    status_check("R9 receiver restarted", 6'h10);
    read_all();
    status_check("R7 after recovery", 6'h08);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule